// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block is the clocked control core of a byte-wide nonvolatile memory that a host accesses like a static RAM. The host drives active-low chip-select, output-enable and write strobes together with an address and a data byte. All of these are asynchronous, so the block first passes them through a two-stage synchroniser. A read drives the stored byte onto the output bus. A write captures its address when the strobes first qualify it and its data when they release it. After that the block runs a timed erase-then-program sequence with no further help from the host.

While a write is in progress, the block pulls its ready/busy line low. Any read in that time returns a status byte in place of stored data: the top bit is the inverse of the byte being written, so the host can poll for completion. Three more functions come with the write path. Writes are locked out for a fixed time after reset and whenever a supply-low flag is raised. A long write pulse while an over-voltage flag on output-enable is set erases the whole main array to all ones. When an over-voltage flag on address line 9 is set, the top 32 addresses of the map reach a separate identification store. The array holds 2^ADDR_W bytes; a full-size instance sets ADDR_W to 13. All time spans are parameters counted in clock cycles.

Top module: `eeprom_byte_ctl`

## Requirements
- R1: `dout_en` is 1 only while the synchronised `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise `dout_en` is 0 and `dout` is 0. After reset, every byte reads 0xFF and `rdy_pull_low` is 0.
- R2: A write cycle is qualified while `ce_n`=0, `we_n`=0, `oe_n`=1 and `oe_hv`=0. Either `we_n` or `ce_n` may be the strobe that opens and closes it. Busy starts only after that qualified period ends.
- R3: The address is captured when the qualified period begins. The data is captured when it ends. Changes in between are ignored.
- R4: If `oe_n` is low during a write strobe, no write starts. If `supply_low` is 1, no write starts. In both cases the addressed byte keeps its old value.
- R5: `rdy_pull_low` stays high for exactly ERASE_CYC+PROG_CYC clock cycles for each write. After that, a read of the written address returns the new byte.
- R6: A read while `rdy_pull_low` is high gives `dout[7]` equal to the inverse of bit 7 of the byte being written, and `dout[6:0]` equal to 0. This holds for any address.
- R7: A write strobe whose qualified period begins while busy is ignored. It changes no byte and starts no further busy period.
- R8: With `oe_hv`=1, `ce_n`=0 and `we_n`=0 held for CHIPCLR_CYC cycles, every main-array byte becomes 0xFF and identification bytes are kept. A shorter pulse changes nothing.
- R9: With `a9_hv`=1, the top 32 addresses (all upper address bits ones) read and write a separate identification store. The main array is left untouched. With `a9_hv`=0, or at lower addresses, the main array is used.
- R10: For PWRUP_CYC cycles after reset, write strobes start no write and change no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_hv | input | 1 | Over-voltage flag on output-enable (array erase mode) |
| a9_hv | input | 1 | Over-voltage flag on address line 9 (identification store) |
| supply_low | input | 1 | Supply below write threshold; blocks writes |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data or poll status |
| dout_en | output | 1 | Output bus drive enable |
| rdy_pull_low | output | 1 | 1 = pull ready/busy line low (write in progress) |

## Verification
Writes are run with write-enable as the strobe and with chip-select as the strobe, so a wrong edge choice in either path shows up. Address and data are changed while the strobe is low, which tells capture on the opening edge apart from capture on the closing edge. Poll reads use data bytes with bit 7 set and with bit 7 clear, so a stuck or non-inverted status bit is caught. A mix of random main-array and identification-window writes, with random strobe choice, is compared against a bench model. Erase pulses shorter and longer than the threshold, and strobes during lockout, supply-low, output-enable-low and busy periods, check that each inhibit leaves bytes untouched.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ERASE = 2'd1,
    WS_PROG  = 2'd2
  } wstate_e;

  // Counter width able to hold values 0..lim
  function automatic int cnt_w(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/eeprom_ctl_sync.sv
module eeprom_ctl_sync #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/eeprom_ctl_wtimer.sv
module eeprom_ctl_wtimer
  import eeprom_ctl_pkg::*;
#(
  parameter int ERASE_CYC = 40000,
  parameter int PROG_CYC  = 160000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic erase_done,
  output logic prog_done
);

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = cnt_w(MAXC);

  wstate_e       state;
  logic [CW-1:0] cnt;

  assign erase_done = (state == WS_ERASE) && (cnt == CW'(ERASE_CYC - 1));
  assign prog_done  = (state == WS_PROG)  && (cnt == CW'(PROG_CYC - 1));
  assign busy       = (state != WS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          cnt <= '0;
          if (launch) state <= WS_ERASE;
        end
        WS_ERASE: begin
          if (erase_done) begin
            state <= WS_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WS_PROG: begin
          if (prog_done) begin
            state <= WS_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= WS_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/eeprom_ctl_store.sv
module eeprom_ctl_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ID_N   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_id,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_all,
  input  logic              rd_id,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int IAW   = $clog2(ID_N);

  logic [DATA_W-1:0] main_q [DEPTH];
  logic [DATA_W-1:0] id_q   [ID_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
      for (int j = 0; j < ID_N; j++)  id_q[j]   <= '1;
    end else begin
      if (clr_all) begin
        for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
      end
      if (wr_en) begin
        if (wr_id) id_q[waddr[IAW-1:0]] <= wdata;
        else       main_q[waddr]        <= wdata;
      end
    end
  end

  assign rdata = rd_id ? id_q[raddr[IAW-1:0]] : main_q[raddr];

endmodule

// File: rtl/eeprom_byte_ctl.sv
module eeprom_byte_ctl
  import eeprom_ctl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ID_BYTES    = 32,
  parameter int ERASE_CYC   = 40000,
  parameter int PROG_CYC    = 160000,
  parameter int PWRUP_CYC   = 1000000,
  parameter int CHIPCLR_CYC = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rdy_pull_low
);

  localparam int IAW = $clog2(ID_BYTES);
  localparam int SW  = 6 + ADDR_W + DATA_W;
  localparam int PUW = cnt_w(PWRUP_CYC);
  localparam int CCW = cnt_w(CHIPCLR_CYC);
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(SW-3){1'b0}}};

  // Top IAW-aligned window of the map: all upper address bits set
  function automatic logic in_id_window(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:IAW];
  endfunction

  // Poll status: inverted MSB of the pending byte, other bits zero
  function automatic logic [DATA_W-1:0] poll_word(input logic msb);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1] = ~msb;
    return w;
  endfunction

  // Synchronised copies of all pins
  logic [SW-1:0]     sync_q;
  logic              ce_s, oe_s, we_s, oe_hv_s, a9_hv_s, slow_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  eeprom_ctl_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce_n, oe_n, we_n, oe_hv, a9_hv, supply_low, addr, din}),
    .q     (sync_q)
  );

  assign {ce_s, oe_s, we_s, oe_hv_s, a9_hv_s, slow_s, addr_s, din_s} = sync_q;

  // Power-up write lockout
  logic [PUW-1:0] pu_cnt;
  logic           pwr_ok;

  assign pwr_ok = (pu_cnt == PUW'(PWRUP_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pu_cnt <= '0;
    else if (!pwr_ok) pu_cnt <= pu_cnt + 1'b1;
  end

  // Write qualification and latching
  logic              busy, erase_done, prog_done;
  logic              wact, wact_q, wr_begin, wr_end, write_ok, wr_launch;
  logic              armed, lat_id;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;

  assign wact      = ~ce_s & ~we_s & oe_s & ~oe_hv_s;
  assign wr_begin  = wact & ~wact_q;
  assign wr_end    = ~wact & wact_q;
  assign write_ok  = pwr_ok & ~slow_s & ~busy;
  assign wr_launch = wr_end & armed & ~slow_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q   <= 1'b0;
      armed    <= 1'b0;
      lat_id   <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      wact_q <= wact;
      if (wr_begin) begin
        armed <= write_ok;
        if (write_ok) begin
          lat_addr <= addr_s;
          lat_id   <= a9_hv_s & in_id_window(addr_s);
        end
      end else if (wr_end) begin
        armed <= 1'b0;
        if (wr_launch) lat_data <= din_s;
      end
    end
  end

  eeprom_ctl_wtimer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (wr_launch),
    .busy       (busy),
    .erase_done (erase_done),
    .prog_done  (prog_done)
  );

  // Whole-array erase on a long high-voltage write pulse
  logic [CCW-1:0] cc_cnt;
  logic           cc_cond, cc_fire;

  assign cc_cond = ~ce_s & ~we_s & oe_hv_s & pwr_ok & ~slow_s & ~busy;
  assign cc_fire = cc_cond & (cc_cnt == CCW'(CHIPCLR_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cc_cnt <= '0;
    else if (!cc_cond)                     cc_cnt <= '0;
    else if (cc_cnt != CCW'(CHIPCLR_CYC))  cc_cnt <= cc_cnt + 1'b1;
  end

  // Storage
  logic              rd_act, rd_id;
  logic [DATA_W-1:0] rdata;

  assign rd_act = ~ce_s & ~oe_s & we_s;
  assign rd_id  = a9_hv_s & in_id_window(addr_s);

  eeprom_ctl_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_N(ID_BYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (erase_done | prog_done),
    .wr_id   (lat_id),
    .waddr   (lat_addr),
    .wdata   (erase_done ? {DATA_W{1'b1}} : lat_data),
    .clr_all (cc_fire),
    .rd_id   (rd_id),
    .raddr   (addr_s),
    .rdata   (rdata)
  );

  // Output path
  assign dout_en      = rd_act;
  assign dout         = !rd_act ? '0 : (busy ? poll_word(lat_data[DATA_W-1]) : rdata);
  assign rdy_pull_low = busy;

endmodule

// File: rtl/eeprom_byte_ctl_chk.sv
module eeprom_byte_ctl_chk #(
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_launch,
  input logic              pwr_ok,
  input logic              dout_en,
  input logic [DATA_W-1:0] dout,
  input logic              launch_msb
);

  localparam int TOTAL = ERASE_CYC + PROG_CYC;

  logic [31:0] bcnt;
  logic        cap_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '0;
      cap_msb <= 1'b0;
    end else begin
      bcnt <= busy ? bcnt + 1 : '0;
      if (wr_launch) cap_msb <= launch_msb;
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == TOTAL)); // R5

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < TOTAL)); // R5

  AST_POLL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> ((dout[DATA_W-1] != cap_msb) && (dout[DATA_W-2:0] == '0))); // R6

  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_launch |-> !busy); // R7

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !wr_launch); // R10

  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_launch)); // R2

endmodule

bind eeprom_byte_ctl eeprom_byte_ctl_chk #(
  .DATA_W    (DATA_W),
  .ERASE_CYC (ERASE_CYC),
  .PROG_CYC  (PROG_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wr_launch  (wr_launch),
  .pwr_ok     (pwr_ok),
  .dout_en    (dout_en),
  .dout       (dout),
  .launch_msb (din_s[DATA_W-1])
);

// File: tb/eeprom_byte_ctl_tb_top.sv
`timescale 1ns/1ps
module eeprom_byte_ctl_tb_top;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int ER  = 4;
  localparam int PG  = 20;
  localparam int TOT = ER + PG;
  localparam int PU  = 60;
  localparam int CC  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic oe_hv = 1'b0, a9_hv = 1'b0, slow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, rdy;

  always #2.5 clk = ~clk;

  eeprom_byte_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .ID_BYTES(32), .ERASE_CYC(ER), .PROG_CYC(PG),
    .PWRUP_CYC(PU), .CHIPCLR_CYC(CC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .oe_hv(oe_hv), .a9_hv(a9_hv), .supply_low(slow), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .rdy_pull_low(rdy)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] m_main [256];
  logic [7:0] m_id   [32];

  function automatic bit is_id(input logic [7:0] a);
    return a >= 8'hE0;
  endfunction

  function automatic logic [7:0] exp_poll(input logic [7:0] d);
    return d[7] ? 8'h00 : 8'h80;
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a, input bit hv);
    return (hv && is_id(a)) ? m_id[a - 8'hE0] : m_main[a];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe a write; returns at the negedge just before busy can appear
  task automatic strobe_write(input logic [7:0] a, input logic [7:0] d, input bit by_ce,
                              input logic [7:0] a_late, input logic [7:0] d_early);
    oe_n = 1'b1; addr = a; din = d_early;
    step(3);
    if (by_ce) begin we_n = 1'b0; step(3); ce_n = 1'b0; end
    else       begin ce_n = 1'b0; step(3); we_n = 1'b0; end
    step(3);
    addr = a_late; din = d;
    step(3);
    if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
    step(2);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rdy) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic read_at(input logic [7:0] a, input bit hv, output logic [7:0] v, output logic e);
    we_n = 1'b1; addr = a; a9_hv = hv; ce_n = 1'b0; oe_n = 1'b0;
    step(4);
    v = dout; e = dout_en;
    oe_n = 1'b1; ce_n = 1'b1;
    step(3);
    a9_hv = 1'b0;
  endtask

  task automatic check_read(input logic [7:0] a, input bit hv, input string req);
    logic [7:0] v;
    logic e;
    read_at(a, hv, v, e);
    chk(e === 1'b1 && v === model_rd(a, hv), req, v, model_rd(a, hv));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v;
    logic e;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_main[i] = 8'hFF;
    for (int i = 0; i < 32; i++)  m_id[i]   = 8'hFF;

    step(5);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    chk(dout_en === 1'b0, "R1 reset dout_en", dout_en, 0);
    chk(rdy === 1'b0, "R1 reset busy", rdy, 0);

    // R10: write during power-up lockout
    strobe_write(8'h05, 8'h3C, 1'b0, 8'h05, 8'h3C);
    wait_busy(n);
    chk(n == 0, "R10 lockout busy", n, 0);
    step(40);
    check_read(8'h05, 1'b0, "R10 lockout byte");

    // R2/R5: write-enable strobe
    strobe_write(8'h10, 8'hA5, 1'b0, 8'h10, 8'hA5);
    wait_busy(n); m_main[8'h10] = 8'hA5;
    chk(n == TOT, "R5 busy length we", n, TOT);
    check_read(8'h10, 1'b0, "R5 readback we");
    // R2: chip-select strobe
    strobe_write(8'h11, 8'h5A, 1'b1, 8'h11, 8'h5A);
    wait_busy(n); m_main[8'h11] = 8'h5A;
    chk(n == TOT, "R2 busy length ce", n, TOT);
    check_read(8'h11, 1'b0, "R2 readback ce");

    // R3: address at opening, data at closing
    strobe_write(8'h12, 8'h77, 1'b0, 8'h13, 8'h11);
    wait_busy(n); m_main[8'h12] = 8'h77;
    check_read(8'h12, 1'b0, "R3 latched addr");
    check_read(8'h13, 1'b0, "R3 late addr untouched");

    // R6: polling
    strobe_write(8'h20, 8'h81, 1'b0, 8'h20, 8'h81);
    read_at(8'h55, 1'b0, v, e);
    chk(e === 1'b1 && v === exp_poll(8'h81), "R6 poll msb1", v, exp_poll(8'h81));
    wait_busy(n); m_main[8'h20] = 8'h81;
    check_read(8'h20, 1'b0, "R6 after poll");
    strobe_write(8'h21, 8'h7F, 1'b1, 8'h21, 8'h7F);
    read_at(8'h21, 1'b0, v, e);
    chk(e === 1'b1 && v === exp_poll(8'h7F), "R6 poll msb0", v, exp_poll(8'h7F));
    wait_busy(n); m_main[8'h21] = 8'h7F;
    check_read(8'h21, 1'b0, "R6 true data");

    // R7: strobe while busy
    strobe_write(8'h30, 8'h11, 1'b0, 8'h30, 8'h11);
    strobe_write(8'h31, 8'h22, 1'b1, 8'h31, 8'h22);
    wait_busy(n); m_main[8'h30] = 8'h11;
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (rdy) n++; end
    chk(n == 0, "R7 no second busy", n, 0);
    check_read(8'h31, 1'b0, "R7 ignored byte");
    check_read(8'h30, 1'b0, "R7 first byte");

    // R4: output-enable low blocks write; R1: no drive while we low
    ce_n = 1'b0; oe_n = 1'b0; addr = 8'h40; din = 8'h99;
    step(3); we_n = 1'b0; step(4);
    chk(dout_en === 1'b0, "R1 no drive during write strobe", dout_en, 0);
    we_n = 1'b1; step(3); ce_n = 1'b1; oe_n = 1'b1;
    wait_busy(n);
    chk(n == 0, "R4 oe low busy", n, 0);
    check_read(8'h40, 1'b0, "R4 oe low byte");
    // R4: supply low
    slow = 1'b1;
    strobe_write(8'h41, 8'h55, 1'b0, 8'h41, 8'h55);
    wait_busy(n);
    slow = 1'b0;
    chk(n == 0, "R4 supply low busy", n, 0);
    check_read(8'h41, 1'b0, "R4 supply low byte");

    // R9: identification window
    a9_hv = 1'b1;
    strobe_write(8'hE3, 8'h6B, 1'b0, 8'hE3, 8'h6B);
    wait_busy(n); a9_hv = 1'b0; m_id[3] = 8'h6B;
    chk(n == TOT, "R9 id busy", n, TOT);
    check_read(8'hE3, 1'b1, "R9 id read");
    check_read(8'hE3, 1'b0, "R9 main under id");
    strobe_write(8'hE5, 8'h44, 1'b1, 8'hE5, 8'h44);
    wait_busy(n); m_main[8'hE5] = 8'h44;
    check_read(8'hE5, 1'b1, "R9 id untouched");
    check_read(8'hE5, 1'b0, "R9 main write");
    a9_hv = 1'b1;
    strobe_write(8'h06, 8'h2E, 1'b0, 8'h06, 8'h2E);
    wait_busy(n); a9_hv = 1'b0; m_main[8'h06] = 8'h2E;
    check_read(8'h06, 1'b0, "R9 low addr uses main");

    // R8: short erase pulse has no effect
    oe_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b0; step(3);
    we_n = 1'b0; step(15); we_n = 1'b1; step(3);
    ce_n = 1'b1; oe_hv = 1'b0; step(3);
    check_read(8'h10, 1'b0, "R8 short pulse");
    // R8: long erase pulse
    oe_hv = 1'b1; ce_n = 1'b0; step(3);
    we_n = 1'b0; step(60); we_n = 1'b1; step(3);
    ce_n = 1'b1; oe_hv = 1'b0; step(3);
    for (int i = 0; i < 256; i++) m_main[i] = 8'hFF;
    n = 0;
    for (int i = 0; i < 256; i++) begin
      read_at(8'(i), 1'b0, v, e);
      if (v !== 8'hFF) n++;
    end
    chk(n == 0, "R8 bytes not erased", n, 0);
    check_read(8'hE3, 1'b1, "R8 id kept");

    // Random writes and readback (R2, R5, R9)
    for (int k = 0; k < 20; k++) begin
      logic [7:0] ra, rd;
      bit hv, bc;
      ra = 8'($urandom); rd = 8'($urandom);
      hv = 1'($urandom); bc = 1'($urandom);
      a9_hv = hv;
      strobe_write(ra, rd, bc, ra, ~rd);
      wait_busy(n);
      a9_hv = 1'b0;
      chk(n == TOT, "R5 random busy length", n, TOT);
      if (hv && is_id(ra)) m_id[ra - 8'hE0] = rd;
      else                 m_main[ra] = rd;
    end
    for (int k = 0; k < 30; k++) begin
      logic [7:0] ra;
      bit hv;
      ra = 8'($urandom); hv = 1'($urandom);
      check_read(ra, hv, "R9 random readback");
    end

    // R1: no drive with oe or ce high
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; step(4);
    chk(dout_en === 1'b0 && dout === 8'h00, "R1 oe high", dout_en, 0);
    ce_n = 1'b1; oe_n = 1'b0; step(4);
    chk(dout_en === 1'b0 && dout === 8'h00, "R1 ce high", dout_en, 0);
    oe_n = 1'b1; step(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule